// File: doc/BRIEF.md
# Interrupt Command Queue Processor

This block drains a circular queue of 32-byte interrupt-management commands held in system memory. The queue's base address, its size in 4 KiB pages, and the producer's write index arrive as inputs; the consumer read index is kept inside the block and shown on an output. While the block is enabled and the read index differs from the write index, it fetches the entry at the read index as four 64-bit words. It then decodes the opcode and runs the command.

The mapping commands are executed by the block itself. They maintain three tables in memory: a device table, per-device translation tables, and a collection table. Each table entry is 8 bytes wide, and all memory traffic uses a single request/acknowledge port. Interrupt, clear and discard commands are passed on as one-cycle requests to a separate translation walker. Pending-state moves are reported as one-cycle move requests. A command that fails validation is dropped, and the read index moves past it. Any memory error raises a sticky stall flag and holds the read index on the offending entry.

Top module: `cmdq_engine`

## Requirements
- R1: Word w (0..3) of the entry at read index i is fetched from base + 32·i + 8·w. Opcode = word0[7:0], device = word0[63:32], event = word1[31:0], upper field = word1[63:32], collection = word2[15:0], target A = word2[47:16], valid = word2[63], table address = word2[51:8], target B = word3[47:16].
- R2: Capacity is (pages_m1+1)·128 entries. After each completed or dropped command the read index becomes (i+1) mod capacity. It resets to 0.
- R3: A memory error on any access (or a missing slot on a command fetch) sets `stalled`. The read index then stays frozen and no further memory request is made until reset.
- R4: Map-device (0x08) writes device entry {valid[0], size[5:1] = word1[4:0], table address bits 51:8 at [49:6]} to dev_base + 8·device, or writes zero when valid is clear. It is dropped when device ≥ DEV_N or size > ID_BITS.
- R5: Map-collection (0x09) writes collection entry {valid[0], target[32:1]} to col_base + 8·collection, or writes zero when valid is clear. It is dropped when collection ≥ COL_N, or when valid is set and target A ≥ CPU_N.
- R6: Map-translated (0x0A) uses the upper field as the interrupt number, and map-interrupt (0x0B) uses the event number. The written translation entry is {valid[0]=1, physical[1]=1, intid[17:2], collection[33:18], doorbell[43:34]=1023}. It goes to (table address·256) + 8·event. Interrupt numbers below 8192 or at or above 2^(ID_BITS+1) are dropped.
- R7: Both map-interrupt forms are dropped when device ≥ DEV_N, the device entry is invalid, event ≥ 2^(size+1), or collection ≥ COL_N.
- R8: Move-interrupt (0x01) reads the translation entry, then the old and new collection entries. All must be valid and in range, or the command is dropped. If the two targets differ, it pulses `move_valid` (move_all=0, src, dst, intid). It then rewrites the translation entry with only the collection changed.
- R9: Move-all (0x0E) pulses `move_valid` with move_all=1, src = target A, dst = target B. It is dropped when either target ≥ CPU_N.
- R10: Interrupt (0x03), clear (0x04) and discard (0x0F) produce one `walk_valid` pulse carrying kind 0, 1 or 2 with the device and event numbers.
- R11: Sync (0x05), invalidate (0x0C, 0x0D) and unknown opcodes have no effect beyond advancing the read index.
- R12: A table write answered with `mem_hole` counts as success. A table read answered with `mem_hole` yields an invalid entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Queue processing enable |
| q_base | input | 64 | Queue base address |
| q_pages_m1 | input | PG_W | Queue size in 4 KiB pages minus one |
| wr_idx | input | IDX_W | Producer write index |
| dev_base | input | 64 | Device table base |
| col_base | input | 64 | Collection table base |
| rd_idx | output | IDX_W | Consumer read index |
| stalled | output | 1 | Sticky memory-error stall flag |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Access failed |
| mem_hole | input | 1 | Address has no backing table slot |
| mem_rdata | input | 64 | Read data |
| walk_valid | output | 1 | Walker request pulse |
| walk_kind | output | 2 | 0 interrupt, 1 clear, 2 discard |
| walk_dev | output | 32 | Device number for the walker |
| walk_event | output | 32 | Event number for the walker |
| move_valid | output | 1 | Pending-state move pulse |
| move_all | output | 1 | Move covers every pending interrupt |
| move_src | output | 32 | Source target |
| move_dst | output | 32 | Destination target |
| move_intid | output | 16 | Interrupt moved (0 for move-all) |

## Verification
With a responder that acknowledges each access in the cycle it is raised, a command takes four fetch cycles and one decode cycle. It then takes one cycle per table read and one per table write, and one final cycle to advance the read index. Walker and move pulses appear in the decode cycle or in the cycle after the last collection read. The index changes one cycle later. Every pulse is compared by a monitor against a scoreboard queue whenever it appears, so its exact cycle does not matter. Memory and index checks wait until the read index reaches the write index, or until the stall flag rises, before they sample at a falling edge.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    localparam logic [7:0] OP_MOVI    = 8'h01;
    localparam logic [7:0] OP_INT     = 8'h03;
    localparam logic [7:0] OP_CLEAR   = 8'h04;
    localparam logic [7:0] OP_SYNC    = 8'h05;
    localparam logic [7:0] OP_MAPD    = 8'h08;
    localparam logic [7:0] OP_MAPC    = 8'h09;
    localparam logic [7:0] OP_MAPTI   = 8'h0A;
    localparam logic [7:0] OP_MAPI    = 8'h0B;
    localparam logic [7:0] OP_INV     = 8'h0C;
    localparam logic [7:0] OP_INVALL  = 8'h0D;
    localparam logic [7:0] OP_MOVALL  = 8'h0E;
    localparam logic [7:0] OP_DISCARD = 8'h0F;

    localparam logic [31:0] FIRST_MSG_ID = 32'd8192;
    localparam logic [9:0]  SPURIOUS_ID  = 10'd1023;

    typedef enum logic [3:0] {
        ST_IDLE, ST_FETCH, ST_EXEC, ST_RD_DEV, ST_RD_XLAT,
        ST_RD_COLD, ST_RD_CNEW, ST_WRITE, ST_ADV, ST_STALL
    } state_e;

    typedef struct packed {
        logic [7:0]  op;
        logic [31:0] devid;
        logic [31:0] evid;
        logic [31:0] upper;
        logic        vbit;
        logic [43:0] tbl;
        logic [15:0] icid;
        logic [31:0] tgt_a;
        logic [31:0] tgt_b;
    } cmd_t;

    function automatic logic [63:0] dev_entry(input logic [4:0] size, input logic [43:0] tbl);
        return {14'd0, tbl, size, 1'b1};
    endfunction

    function automatic logic [63:0] xlat_entry(input logic [15:0] intid, input logic [15:0] icid);
        return {20'd0, SPURIOUS_ID, icid, intid, 1'b1, 1'b1};
    endfunction

    function automatic logic [63:0] coll_entry(input logic [31:0] tgt);
        return {31'd0, tgt, 1'b1};
    endfunction

endpackage

// File: rtl/cmdq_ring.sv
module cmdq_ring #(
    parameter int PG_W  = 8,
    parameter int IDX_W = PG_W + 7
) (
    input  logic [63:0]      base,
    input  logic [PG_W-1:0]  pages_m1,
    input  logic [IDX_W-1:0] rd,
    input  logic [1:0]       word,
    output logic [IDX_W:0]   cap,
    output logic [63:0]      fetch_addr,
    output logic [IDX_W-1:0] rd_next
);
    logic [IDX_W:0] pages;
    logic [IDX_W:0] inc;

    always_comb begin
        pages      = (IDX_W+1)'(pages_m1) + 1'b1;
        cap        = pages << 7;
        fetch_addr = base + 64'({rd, 5'b0}) + 64'({word, 3'b0});
        inc        = {1'b0, rd} + 1'b1;
        rd_next    = (inc == cap) ? '0 : inc[IDX_W-1:0];
    end
endmodule

// File: rtl/cmdq_merge.sv
module cmdq_merge
    import cmdq_pkg::*;
(
    input  cmd_t        cur,
    input  logic [1:0]  word,
    input  logic [63:0] data,
    output cmd_t        nxt
);
    logic unused_bits;
    assign unused_bits = ^data[62:52];

    always_comb begin
        nxt = cur;
        case (word)
            2'd0: begin
                nxt.op    = data[7:0];
                nxt.devid = data[63:32];
            end
            2'd1: begin
                nxt.evid  = data[31:0];
                nxt.upper = data[63:32];
            end
            2'd2: begin
                nxt.vbit  = data[63];
                nxt.tbl   = data[51:8];
                nxt.icid  = data[15:0];
                nxt.tgt_a = data[47:16];
            end
            default: nxt.tgt_b = data[47:16];
        endcase
    end
endmodule

// File: rtl/cmdq_engine.sv
module cmdq_engine
    import cmdq_pkg::*;
#(
    parameter int DEV_N   = 64,
    parameter int COL_N   = 16,
    parameter int CPU_N   = 4,
    parameter int ID_BITS = 15,
    parameter int PG_W    = 8,
    localparam int IDX_W  = PG_W + 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [63:0]      q_base,
    input  logic [PG_W-1:0]  q_pages_m1,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [63:0]      dev_base,
    input  logic [63:0]      col_base,
    output logic [IDX_W-1:0] rd_idx,
    output logic             stalled,
    output logic             mem_req,
    output logic             mem_we,
    output logic [63:0]      mem_addr,
    output logic [63:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic             mem_err,
    input  logic             mem_hole,
    input  logic [63:0]      mem_rdata,
    output logic             walk_valid,
    output logic [1:0]       walk_kind,
    output logic [31:0]      walk_dev,
    output logic [31:0]      walk_event,
    output logic             move_valid,
    output logic             move_all,
    output logic [31:0]      move_src,
    output logic [31:0]      move_dst,
    output logic [15:0]      move_intid
);
    localparam logic [32:0] INT_LIM = 33'd1 << (ID_BITS + 1);

    typedef struct packed {
        state_e          st;
        logic [1:0]      word;
        cmd_t            cmd;
        logic [4:0]      dsize;
        logic [43:0]     dtbl;
        logic [63:0]     xlat;
        logic [31:0]     old_tgt;
        logic [63:0]     waddr;
        logic [63:0]     wdata;
        logic [IDX_W-1:0] rd;
        logic            stall;
        logic            wv;
        logic [1:0]      wk;
        logic            mv;
        logic            mall;
        logic [31:0]     msrc;
        logic [31:0]     mdst;
        logic [15:0]     mint;
    } regs_t;

    regs_t q, d;

    logic [IDX_W:0]   cap;
    logic [63:0]      fetch_addr;
    logic [IDX_W-1:0] rd_next;
    cmd_t             merged;

    cmdq_ring #(.PG_W(PG_W), .IDX_W(IDX_W)) ring_i (
        .base(q_base), .pages_m1(q_pages_m1), .rd(q.rd), .word(q.word),
        .cap(cap), .fetch_addr(fetch_addr), .rd_next(rd_next)
    );

    cmdq_merge merge_i (
        .cur(q.cmd), .word(q.word), .data(mem_rdata), .nxt(merged)
    );

    // Addresses derived from the held command and table entries
    logic [63:0] dev_addr, xlat_addr, cold_addr, cnew_addr;
    always_comb begin
        dev_addr  = dev_base + {29'd0, q.cmd.devid, 3'b0};
        xlat_addr = {12'd0, q.dtbl, 8'd0} + {29'd0, q.cmd.evid, 3'b0};
        cold_addr = col_base + {45'd0, q.xlat[33:18], 3'b0};
        cnew_addr = col_base + {45'd0, q.cmd.icid, 3'b0};
    end

    always_comb begin
        logic        ent_v;
        logic [4:0]  sz;
        logic        ev_oob;
        logic [31:0] intid;
        logic [63:0] x;
        logic [31:0] tgt;
        d = q;
        d.wv = 1'b0;
        d.mv = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = fetch_addr;
        mem_wdata = q.wdata;
        ent_v  = mem_rdata[0] & ~mem_hole;
        sz     = mem_rdata[5:1];
        ev_oob = (({32'd0, q.cmd.evid} >> (6'd1 + {1'b0, sz})) != 64'd0);
        intid  = (q.cmd.op == OP_MAPI) ? q.cmd.evid : q.cmd.upper;
        x      = mem_hole ? 64'd0 : mem_rdata;
        tgt    = mem_rdata[32:1];
        case (q.st)
            ST_IDLE: begin
                if (enable && !q.stall && q.rd != wr_idx) begin
                    d.st   = ST_FETCH;
                    d.word = 2'd0;
                end
            end
            ST_FETCH: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    if (mem_err || mem_hole) begin
                        d.st = ST_STALL; d.stall = 1'b1;
                    end else begin
                        d.cmd = merged;
                        if (q.word == 2'd3) d.st = ST_EXEC;
                        else d.word = q.word + 2'd1;
                    end
                end
            end
            ST_EXEC: begin
                d.st = ST_ADV;
                case (q.cmd.op)
                    OP_MAPD: begin
                        if (q.cmd.devid < 32'(DEV_N) && q.cmd.evid[4:0] <= 5'(ID_BITS)) begin
                            d.waddr = dev_addr;
                            d.wdata = q.cmd.vbit ? dev_entry(q.cmd.evid[4:0], q.cmd.tbl) : 64'd0;
                            d.st    = ST_WRITE;
                        end
                    end
                    OP_MAPC: begin
                        if (q.cmd.icid < 16'(COL_N) &&
                            !(q.cmd.vbit && q.cmd.tgt_a >= 32'(CPU_N))) begin
                            d.waddr = cnew_addr;
                            d.wdata = q.cmd.vbit ? coll_entry(q.cmd.tgt_a) : 64'd0;
                            d.st    = ST_WRITE;
                        end
                    end
                    OP_MAPTI, OP_MAPI, OP_MOVI: begin
                        if (q.cmd.devid < 32'(DEV_N)) d.st = ST_RD_DEV;
                    end
                    OP_MOVALL: begin
                        if (q.cmd.tgt_a < 32'(CPU_N) && q.cmd.tgt_b < 32'(CPU_N)) begin
                            d.mv = 1'b1; d.mall = 1'b1;
                            d.msrc = q.cmd.tgt_a; d.mdst = q.cmd.tgt_b; d.mint = 16'd0;
                        end
                    end
                    OP_INT:     begin d.wv = 1'b1; d.wk = 2'd0; end
                    OP_CLEAR:   begin d.wv = 1'b1; d.wk = 2'd1; end
                    OP_DISCARD: begin d.wv = 1'b1; d.wk = 2'd2; end
                    default: ;
                endcase
            end
            ST_RD_DEV: begin
                mem_req  = 1'b1;
                mem_addr = dev_addr;
                if (mem_ack) begin
                    d.dsize = sz;
                    d.dtbl  = mem_rdata[49:6];
                    if (mem_err) begin
                        d.st = ST_STALL; d.stall = 1'b1;
                    end else if (!ent_v || ev_oob) begin
                        d.st = ST_ADV;
                    end else if (q.cmd.op == OP_MOVI) begin
                        d.st = ST_RD_XLAT;
                    end else if (q.cmd.icid >= 16'(COL_N) || intid < FIRST_MSG_ID ||
                                 {1'b0, intid} >= INT_LIM) begin
                        d.st = ST_ADV;
                    end else begin
                        d.waddr = {12'd0, mem_rdata[49:6], 8'd0} + {29'd0, q.cmd.evid, 3'b0};
                        d.wdata = xlat_entry(intid[15:0], q.cmd.icid);
                        d.st    = ST_WRITE;
                    end
                end
            end
            ST_RD_XLAT: begin
                mem_req  = 1'b1;
                mem_addr = xlat_addr;
                if (mem_ack) begin
                    d.xlat = x;
                    if (mem_err) begin
                        d.st = ST_STALL; d.stall = 1'b1;
                    end else if (!x[0] || !x[1] || x[33:18] >= 16'(COL_N) ||
                                 q.cmd.icid >= 16'(COL_N)) begin
                        d.st = ST_ADV;
                    end else begin
                        d.st = ST_RD_COLD;
                    end
                end
            end
            ST_RD_COLD: begin
                mem_req  = 1'b1;
                mem_addr = cold_addr;
                if (mem_ack) begin
                    d.old_tgt = tgt;
                    if (mem_err) begin
                        d.st = ST_STALL; d.stall = 1'b1;
                    end else d.st = ent_v ? ST_RD_CNEW : ST_ADV;
                end
            end
            ST_RD_CNEW: begin
                mem_req  = 1'b1;
                mem_addr = cnew_addr;
                if (mem_ack) begin
                    if (mem_err) begin
                        d.st = ST_STALL; d.stall = 1'b1;
                    end else if (!ent_v || q.old_tgt >= 32'(CPU_N) || tgt >= 32'(CPU_N)) begin
                        d.st = ST_ADV;
                    end else begin
                        if (q.old_tgt != tgt) begin
                            d.mv = 1'b1; d.mall = 1'b0;
                            d.msrc = q.old_tgt; d.mdst = tgt; d.mint = q.xlat[17:2];
                        end
                        d.waddr = xlat_addr;
                        d.wdata = {q.xlat[63:34], q.cmd.icid, q.xlat[17:0]};
                        d.st    = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = q.waddr;
                if (mem_ack) begin
                    if (mem_err) begin
                        d.st = ST_STALL; d.stall = 1'b1;
                    end else d.st = ST_ADV;
                end
            end
            ST_ADV: begin
                d.rd = rd_next;
                d.st = ST_IDLE;
            end
            default: d.stall = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign rd_idx     = q.rd;
    assign stalled    = q.stall;
    assign walk_valid = q.wv;
    assign walk_kind  = q.wk;
    assign walk_dev   = q.cmd.devid;
    assign walk_event = q.cmd.evid;
    assign move_valid = q.mv;
    assign move_all   = q.mall;
    assign move_src   = q.msrc;
    assign move_dst   = q.mdst;
    assign move_intid = q.mint;

    assert_rd_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, rd_idx} < cap) else $error("read index beyond capacity");

    assert_rd_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx != $past(rd_idx)) |-> (rd_idx == '0 || rd_idx == $past(rd_idx) + 1'b1))
        else $error("read index moved by more than one entry");

    assert_err_stalls_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_err) |=> stalled) else $error("error without stall");

    assert_stall_freezes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stalled |=> (stalled && !mem_req && $stable(rd_idx))) else $error("stall not frozen");

    assert_hole_write_ok_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack && mem_hole && !mem_err && !stalled) |=> !stalled)
        else $error("hole write caused stall");

    assert_move_differs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (move_valid && !move_all) |-> (move_src != move_dst)) else $error("move to same target");

    assert_walk_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        walk_valid |=> !walk_valid) else $error("walker request longer than one cycle");

endmodule

// File: tb/cmdq_engine_tb_top.sv
module cmdq_engine_tb_top;
    import cmdq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int IDX_W = 15;
    localparam logic [63:0] QB  = 64'h1000_0000;
    localparam logic [63:0] DT  = 64'h2000_0000;
    localparam logic [63:0] CT  = 64'h3000_0000;
    localparam logic [63:0] ITT = 64'h0004_0000;
    localparam int CAP = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic [IDX_W-1:0] rd_idx;
    logic stalled, mem_req, mem_we;
    logic [63:0] mem_addr, mem_wdata;
    logic mem_ack = 1'b0, mem_err = 1'b0, mem_hole = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic walk_valid, move_valid, move_all;
    logic [1:0] walk_kind;
    logic [31:0] walk_dev, walk_event, move_src, move_dst;
    logic [15:0] move_intid;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmdq_engine dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .q_base(QB), .q_pages_m1(8'd0),
        .wr_idx(wr_idx), .dev_base(DT), .col_base(CT), .rd_idx(rd_idx), .stalled(stalled),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .mem_hole(mem_hole), .mem_rdata(mem_rdata),
        .walk_valid(walk_valid), .walk_kind(walk_kind), .walk_dev(walk_dev),
        .walk_event(walk_event), .move_valid(move_valid), .move_all(move_all),
        .move_src(move_src), .move_dst(move_dst), .move_intid(move_intid)
    );

    logic [63:0] mem [logic [63:0]];
    bit holes [logic [63:0]];
    bit errs  [logic [63:0]];

    // Memory responder: answers each request in the cycle it is seen
    always @(negedge clk) begin
        mem_ack   = mem_req;
        mem_err   = 1'b0;
        mem_hole  = 1'b0;
        mem_rdata = '0;
        if (mem_req) begin
            if (errs.exists(mem_addr)) mem_err = 1'b1;
            else if (holes.exists(mem_addr)) mem_hole = 1'b1;
            else if (mem_we) mem[mem_addr] = mem_wdata;
            else if (mem.exists(mem_addr)) mem_rdata = mem[mem_addr];
        end
    end

    // Scoreboard item: {req tag string index, kind tag, f1, f2, f3, f4}
    typedef struct packed {
        logic [7:0]  tag;
        logic [31:0] f1, f2, f3, f4;
    } item_t;
    item_t expq[$];
    string expr[$];

    task automatic push_walk(input string r, input logic [1:0] k, input logic [31:0] dv, ev);
        expq.push_back('{8'd1, {30'd0, k}, dv, ev, 32'd0});
        expr.push_back(r);
    endtask

    task automatic push_move(input string r, input logic all, input logic [31:0] s, t, input logic [15:0] id);
        expq.push_back('{8'd2, {31'd0, all}, s, t, {16'd0, id}});
        expr.push_back(r);
    endtask

    always @(negedge clk) begin
        if (rst_n && (walk_valid || move_valid)) begin
            item_t got;
            if (walk_valid) got = '{8'd1, {30'd0, walk_kind}, walk_dev, walk_event, 32'd0};
            else got = '{8'd2, {31'd0, move_all}, move_src, move_dst, {16'd0, move_intid}};
            n_chk++;
            if (expq.size() == 0) begin
                n_fail++;
                $display("FAIL R11 unexpected pulse actual=%h expected=none", got);
            end else begin
                item_t e;
                string r;
                e = expq.pop_front();
                r = expr.pop_front();
                if (e != got) begin
                    n_fail++;
                    $display("FAIL %s pulse actual=%h expected=%h", r, got, e);
                end
            end
        end
    end

    task automatic check(input string r, input string what, input logic [63:0] act, exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    function automatic logic [63:0] rd_mem(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'hFFFF_FFFF_FFFF_FFFF;
    endfunction

    task automatic wait_done();
        int n = 0;
        @(negedge clk);
        while (!(rd_idx == wr_idx || stalled) && n < 400) begin
            @(negedge clk);
            n++;
        end
        if (n >= 400) begin
            n_fail++;
            $display("FAIL R1 command did not complete actual=%0d expected=%0d", rd_idx, wr_idx);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic issue(input logic [63:0] w0, w1, w2, w3);
        logic [63:0] b;
        b = QB + 64'(wr_idx) * 32;
        mem[b] = w0; mem[b+8] = w1; mem[b+16] = w2; mem[b+24] = w3;
        wr_idx = (int'(wr_idx) + 1 == CAP) ? '0 : wr_idx + 1'b1;
        wait_done();
    endtask

    function automatic logic [63:0] w0f(input logic [7:0] op, input logic [31:0] dv);
        return {dv, 24'd0, op};
    endfunction

    function automatic logic [63:0] tgtw(input logic v, input logic [31:0] t, input logic [15:0] ic);
        return {v, 15'd0, t, ic};
    endfunction

    function automatic logic [63:0] dte(input logic [4:0] sz, input logic [63:0] a);
        return {14'd0, a[51:8], sz, 1'b1};
    endfunction

    function automatic logic [63:0] ite(input logic [15:0] id, input logic [15:0] ic);
        return {20'd0, 10'd1023, ic, id, 2'b11};
    endfunction

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [IDX_W-1:0] k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", "reset rd_idx", 64'(rd_idx), 64'd0);
        check("R3", "reset stalled", 64'(stalled), 64'd0);
        check("R1", "reset mem_req", 64'(mem_req), 64'd0);
        enable = 1'b1;

        // R4 map-device
        issue(w0f(OP_MAPD, 3), 64'd4, 64'h8000_0000_0000_0000 | ITT, 0);
        check("R4", "dev3 entry", rd_mem(DT + 24), dte(5'd4, ITT));
        check("R2", "rd after first", 64'(rd_idx), 64'd1);
        mem[DT + 70*8] = 64'hDEAD;
        issue(w0f(OP_MAPD, 70), 64'd4, 64'h8000_0000_0000_0000 | ITT, 0);
        check("R4", "dev out of range", rd_mem(DT + 70*8), 64'hDEAD);
        mem[DT + 32] = 64'd77;
        issue(w0f(OP_MAPD, 4), 64'd16, 64'h8000_0000_0000_0000 | ITT, 0);
        check("R4", "size too big", rd_mem(DT + 32), 64'd77);
        mem[DT + 40] = 64'd99;
        issue(w0f(OP_MAPD, 5), 64'd4, ITT, 0);
        check("R4", "unmap dev", rd_mem(DT + 40), 64'd0);

        // R5 map-collection
        issue(w0f(OP_MAPC, 0), 0, tgtw(1, 1, 2), 0);
        check("R5", "col2", rd_mem(CT + 16), 64'd3);
        issue(w0f(OP_MAPC, 0), 0, tgtw(1, 3, 7), 0);
        check("R5", "col7", rd_mem(CT + 56), 64'd7);
        mem[CT + 40] = 64'd55;
        issue(w0f(OP_MAPC, 0), 0, tgtw(1, 9, 5), 0);
        check("R5", "bad target", rd_mem(CT + 40), 64'd55);
        mem[CT + 48] = 64'd66;
        issue(w0f(OP_MAPC, 0), 0, tgtw(0, 9, 6), 0);
        check("R5", "unmap col", rd_mem(CT + 48), 64'd0);
        mem[CT + 160] = 64'd88;
        issue(w0f(OP_MAPC, 0), 0, tgtw(1, 1, 20), 0);
        check("R5", "col out of range", rd_mem(CT + 160), 64'd88);

        // R6 interrupt numbers
        issue(w0f(OP_MAPTI, 3), {32'd8200, 32'd5}, 64'd2, 0);
        check("R6", "map ev5", rd_mem(ITT + 40), ite(16'd8200, 16'd2));
        mem[ITT + 48] = 64'h1234;
        issue(w0f(OP_MAPTI, 3), {32'd8191, 32'd6}, 64'd2, 0);
        check("R6", "intid below first", rd_mem(ITT + 48), 64'h1234);
        issue(w0f(OP_MAPTI, 3), {32'd65536, 32'd6}, 64'd2, 0);
        check("R6", "intid above limit", rd_mem(ITT + 48), 64'h1234);
        issue(w0f(OP_MAPTI, 3), {32'd65535, 32'd7}, 64'd2, 0);
        check("R6", "intid at top", rd_mem(ITT + 56), ite(16'd65535, 16'd2));
        mem[ITT + 64] = 64'h4321;
        issue(w0f(OP_MAPI, 3), {32'd9000, 32'd8}, 64'd2, 0);
        check("R6", "map-interrupt uses event", rd_mem(ITT + 64), 64'h4321);

        // R7 drops
        mem[ITT + 256] = 64'h5;
        issue(w0f(OP_MAPTI, 3), {32'd9000, 32'd32}, 64'd2, 0);
        check("R7", "event out of range", rd_mem(ITT + 256), 64'h5);
        issue(w0f(OP_MAPTI, 3), {32'd9000, 32'd31}, 64'd2, 0);
        check("R7", "last event", rd_mem(ITT + 248), ite(16'd9000, 16'd2));
        mem[DT + 72] = dte(5'd4, ITT) & ~64'd1;
        mem[ITT + 80] = 64'h6;
        issue(w0f(OP_MAPTI, 9), {32'd9000, 32'd10}, 64'd2, 0);
        check("R7", "invalid device entry", rd_mem(ITT + 80), 64'h6);
        mem[ITT + 88] = 64'h7;
        issue(w0f(OP_MAPTI, 3), {32'd9000, 32'd11}, 64'd16, 0);
        check("R7", "collection out of range", rd_mem(ITT + 88), 64'h7);

        // R8 move-interrupt
        push_move("R8", 1'b0, 32'd1, 32'd3, 16'd8200);
        issue(w0f(OP_MOVI, 3), 64'd5, 64'd7, 0);
        check("R8", "movi to col7", rd_mem(ITT + 40), ite(16'd8200, 16'd7));
        mem[CT + 64] = 64'd7;
        issue(w0f(OP_MOVI, 3), 64'd5, 64'd8, 0);
        check("R8", "movi same target", rd_mem(ITT + 40), ite(16'd8200, 16'd8));
        issue(w0f(OP_MOVI, 3), 64'd5, 64'd9, 0);
        check("R8", "movi invalid new col", rd_mem(ITT + 40), ite(16'd8200, 16'd8));

        // R9 move-all
        push_move("R9", 1'b1, 32'd0, 32'd2, 16'd0);
        issue(w0f(OP_MOVALL, 0), 0, tgtw(0, 0, 0), tgtw(0, 2, 0));
        issue(w0f(OP_MOVALL, 0), 0, tgtw(0, 0, 0), tgtw(0, 4, 0));
        check("R9", "pending moves", 64'(expq.size()), 64'd0);

        // R10 walker handoff
        push_walk("R10", 2'd0, 32'd12, 32'd34);
        issue(w0f(OP_INT, 12), 64'd34, 0, 0);
        push_walk("R10", 2'd1, 32'd13, 32'd35);
        issue(w0f(OP_CLEAR, 13), 64'd35, 0, 0);
        push_walk("R10", 2'd2, 32'd14, 32'd36);
        issue(w0f(OP_DISCARD, 14), 64'd36, 0, 0);
        check("R10", "walks consumed", 64'(expq.size()), 64'd0);

        // R11 no-effect opcodes
        issue(w0f(OP_SYNC, 3), 64'd4, 64'h8000_0000_0000_0000, 0);
        issue(w0f(OP_INV, 3), 64'd4, 64'h8000_0000_0000_0000, 0);
        issue(w0f(OP_INVALL, 3), 64'd4, 64'h8000_0000_0000_0000, 0);
        issue(w0f(8'hFF, 3), 64'd4, 64'h8000_0000_0000_0000, 0);
        check("R11", "dev3 untouched", rd_mem(DT + 24), dte(5'd4, ITT));
        check("R11", "queue drained", 64'(rd_idx), 64'(wr_idx));

        // R12 missing table slots
        holes[DT + 13*8] = 1'b1;
        issue(w0f(OP_MAPD, 13), 64'd4, 64'h8000_0000_0000_0000 | ITT, 0);
        check("R12", "hole write no stall", 64'(stalled), 64'd0);
        check("R12", "hole write advances", 64'(rd_idx), 64'(wr_idx));
        mem[ITT + 8] = 64'h9;
        issue(w0f(OP_MAPTI, 13), {32'd9000, 32'd1}, 64'd2, 0);
        check("R12", "hole read invalid", rd_mem(ITT + 8), 64'h9);
        check("R12", "hole read no stall", 64'(stalled), 64'd0);

        // R2 wrap-around
        while (int'(wr_idx) != CAP - 1) issue(w0f(OP_SYNC, 0), 0, 0, 0);
        check("R2", "rd at last entry", 64'(rd_idx), 64'(CAP - 1));
        issue(w0f(OP_SYNC, 0), 0, 0, 0);
        check("R2", "rd wraps", 64'(rd_idx), 64'd0);
        issue(w0f(OP_MAPD, 6), 64'd3, 64'h8000_0000_0000_0000 | ITT, 0);
        check("R1", "fetch after wrap", rd_mem(DT + 48), dte(5'd3, ITT));

        // R3 stall on fetch error
        k = wr_idx;
        errs[QB + 64'(k) * 32 + 8] = 1'b1;
        mem[CT + 24] = 64'd44;
        issue(w0f(OP_MAPC, 0), 0, tgtw(1, 0, 3), 0);
        check("R3", "stalled set", 64'(stalled), 64'd1);
        check("R3", "rd frozen", 64'(rd_idx), 64'(k));
        repeat (20) @(negedge clk);
        check("R3", "no request while stalled", 64'(mem_req), 64'd0);
        check("R3", "rd still frozen", 64'(rd_idx), 64'(k));
        check("R3", "command not run", rd_mem(CT + 24), 64'd44);
        check("R10", "scoreboard empty", 64'(expq.size()), 64'd0);
        finish_run();
    end
endmodule